// File: doc/BRIEF.md
# Logic Analyzer Serial Command Decoder

This block sits between the byte-level receiver and transmitter of a small logic analyzer and the rest of its control logic. Every received byte is fed to a framing state machine that decides from the first byte alone whether a command is a single byte or a five-byte command. A five-byte command is an opcode followed by a 32-bit argument sent least significant byte first. A completed long command is handed downstream as a single-cycle write pulse together with its opcode and argument. Short commands become single-cycle control pulses: reset, run and metadata request. An identify request starts a reply sequencer that hands the fixed four-byte answer to the transmitter, one byte per ready handshake.

The host cannot know where the device is inside a five-byte command after a link upset. To recover, it sends the zero byte five times. The framer therefore needs no timeout. A run of five zero bytes always leaves it idle, because zeros either finish the pending argument or are taken as reset commands.

Framer states: `F_IDLE` (waiting for an opcode) and `F_ARG` (collecting argument bytes). Its transitions are *long opcode seen* (`F_IDLE`→`F_ARG`) and *last argument byte seen* (`F_ARG`→`F_IDLE`). Reply states: `R_IDLE` and `R_SEND`. Its transitions are *identify pulse* (`R_IDLE`→`R_SEND`) and *last byte accepted* (`R_SEND`→`R_IDLE`).

Top module: `la_cmd_decoder`

## Requirements
- R1: A received opcode byte with bit 7 clear is a complete one-byte command. An opcode with bit 7 set is followed by exactly four argument bytes, and only then is a new opcode accepted.
- R2: In the cycle after the fourth argument byte is accepted, `wr_stb` is high for exactly one cycle. During that cycle `wr_opcode` carries the opcode and `wr_arg` carries the argument, with the first argument byte in bits 7:0 and the last in bits 31:24.
- R3: Opcode 0x00 received while the framer is idle raises `reset_stb` for one cycle, in the cycle after the byte is accepted.
- R4: After any five consecutive accepted 0x00 bytes the framer is idle, whatever partial command was in progress. The byte after them is therefore decoded as an opcode.
- R5: Opcode 0x01 raises `run_stb` for one cycle and opcode 0x04 raises `meta_stb` for one cycle, each in the cycle after the byte. Opcode 0x04 causes no transmit activity.
- R6: Opcode 0x02 starts a reply of the bytes 0x31, 0x53, 0x4C, 0x4F ("1SLO") in that order. `tx_valid` first rises two cycles after the request byte is accepted.
- R7: A reply byte is presented with `tx_valid` high and held unchanged until a cycle with `tx_ready` high. `tx_valid` falls after the fourth byte is accepted.
- R8: An identify request that arrives while a reply is in progress is ignored. No reply bytes are added or restarted.
- R9: Short opcodes other than 0x00, 0x01, 0x02 and 0x04 raise no output. After reset, every strobe and `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter accepts the presented byte this cycle |
| tx_valid | output | 1 | A reply byte is presented |
| tx_byte | output | 8 | Reply byte |
| wr_stb | output | 1 | Long command complete (one cycle) |
| wr_opcode | output | 8 | Opcode of the completed long command |
| wr_arg | output | 32 | Assembled argument of the long command |
| reset_stb | output | 1 | Reset command pulse |
| run_stb | output | 1 | Run command pulse |
| meta_stb | output | 1 | Metadata request pulse |

## Verification
A framer stuck in the wrong state or at the wrong byte index would misplace the next command boundary. The effect shows at the ports within one to five bytes, as a missing or extra strobe, or as an argument with shifted bytes. A reply sequencer whose index or state drifts would show a wrong byte, a duplicate or an extra `tx_valid` cycle at the next handshake. The bench compares every output against a behavioural model on every clock, so such faults appear in the first cycle in which they become visible.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;
    localparam int BYTE_W    = 8;
    localparam int ARG_BYTES = 4;
    localparam int ARG_W     = BYTE_W * ARG_BYTES;
    localparam int ID_LEN    = 4;

    localparam logic [BYTE_W-1:0] OP_RESET = 8'h00;
    localparam logic [BYTE_W-1:0] OP_RUN   = 8'h01;
    localparam logic [BYTE_W-1:0] OP_IDENT = 8'h02;
    localparam logic [BYTE_W-1:0] OP_META  = 8'h04;

    typedef enum logic { F_IDLE, F_ARG } frm_state_t;
    typedef enum logic { R_IDLE, R_SEND } rep_state_t;

    function automatic logic [BYTE_W-1:0] id_byte(input logic [1:0] idx);
        logic [BYTE_W-1:0] b;
        unique case (idx)
            2'd0: b = 8'h31;
            2'd1: b = 8'h53;
            2'd2: b = 8'h4C;
            default: b = 8'h4F;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/la_cmd_framer.sv
module la_cmd_framer
    import la_cmd_pkg::*;
#(
    parameter int N_ARG = ARG_BYTES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic [BYTE_W-1:0]       rx_byte,
    output logic                    short_v,
    output logic [BYTE_W-1:0]       short_op,
    output logic                    long_v,
    output logic [BYTE_W-1:0]       long_op,
    output logic [BYTE_W*N_ARG-1:0] long_arg
);
    localparam int AW    = BYTE_W * N_ARG;
    localparam int IDX_W = (N_ARG > 1) ? $clog2(N_ARG) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ARG - 1);
    localparam int ZRUN_MAX = N_ARG + 1;
    localparam int ZW = $clog2(ZRUN_MAX + 1);

    frm_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [BYTE_W-1:0] op_q, op_d;
    logic [AW-1:0]     arg_q, arg_d;
    logic              last_byte;

    assign last_byte = rx_valid && (state_q == F_ARG) && (idx_q == LAST_IDX);

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        op_d    = op_q;
        arg_d   = arg_q;
        unique case (state_q)
            F_IDLE: begin
                if (rx_valid && rx_byte[BYTE_W-1]) begin
                    state_d = F_ARG;
                    idx_d   = '0;
                    op_d    = rx_byte;
                    arg_d   = '0;
                end
            end
            F_ARG: begin
                if (rx_valid) begin
                    arg_d[BYTE_W*idx_q +: BYTE_W] = rx_byte;
                    if (idx_q == LAST_IDX) begin
                        state_d = F_IDLE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= F_IDLE;
            idx_q   <= '0;
            op_q    <= '0;
            arg_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            op_q    <= op_d;
            arg_q   <= arg_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            short_v  <= 1'b0;
            short_op <= '0;
            long_v   <= 1'b0;
            long_op  <= '0;
            long_arg <= '0;
        end else begin
            short_v <= rx_valid && (state_q == F_IDLE) && !rx_byte[BYTE_W-1];
            long_v  <= last_byte;
            if (rx_valid && (state_q == F_IDLE)) begin
                short_op <= rx_byte;
            end
            if (last_byte) begin
                long_op  <= op_q;
                long_arg <= arg_d;
            end
        end
    end

    logic [ZW-1:0] zrun_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zrun_q <= '0;
        end else if (rx_valid) begin
            if (rx_byte != '0) begin
                zrun_q <= '0;
            end else if (zrun_q != ZW'(ZRUN_MAX)) begin
                zrun_q <= zrun_q + 1'b1;
            end
        end
    end

    // R4
    zero_run_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zrun_q == ZW'(ZRUN_MAX)) |-> (state_q == F_IDLE));

    // R2
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        long_v |=> !long_v);

    // R1
    no_mixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(short_v && long_v));
endmodule

// File: rtl/la_id_reply.sv
module la_id_reply
    import la_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_req,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte
);
    localparam int IW = $clog2(ID_LEN);
    localparam logic [IW-1:0] LAST = IW'(ID_LEN - 1);

    rep_state_t    state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;
    logic          take;

    assign take = (state_q == R_SEND) && tx_ready;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            R_IDLE: begin
                if (id_req) begin
                    state_d = R_SEND;
                    idx_d   = '0;
                end
            end
            R_SEND: begin
                if (take) begin
                    if (idx_q == LAST) begin
                        state_d = R_IDLE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= R_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        tx_valid = (state_q == R_SEND);
        tx_byte  = tx_valid ? id_byte(idx_q) : '0;
    end

    // R7
    hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    // R7
    end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_byte == 8'h4F) |=> !tx_valid);

    // R6
    first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> (tx_byte == 8'h31));
endmodule

// File: rtl/la_cmd_decoder.sv
module la_cmd_decoder
    import la_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        tx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic        wr_stb,
    output logic [7:0]  wr_opcode,
    output logic [31:0] wr_arg,
    output logic        reset_stb,
    output logic        run_stb,
    output logic        meta_stb
);
    logic              short_v;
    logic [BYTE_W-1:0] short_op;
    logic              id_req;

    la_cmd_framer #(.N_ARG(ARG_BYTES)) framer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .short_v  (short_v),
        .short_op (short_op),
        .long_v   (wr_stb),
        .long_op  (wr_opcode),
        .long_arg (wr_arg)
    );

    always_comb begin
        reset_stb = short_v && (short_op == OP_RESET);
        run_stb   = short_v && (short_op == OP_RUN);
        meta_stb  = short_v && (short_op == OP_META);
        id_req    = short_v && (short_op == OP_IDENT);
    end

    la_id_reply reply_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .id_req   (id_req),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte)
    );

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reset_stb, run_stb, meta_stb, wr_stb}));

    // R3
    reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_stb |-> !$past(reset_stb) || $past(rx_valid, 2));
endmodule

// File: tb/la_cmd_decoder_tb_top.sv
module la_cmd_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        tx_ready = 1'b0;
    logic        tx_valid, wr_stb, reset_stb, run_stb, meta_stb;
    logic [7:0]  tx_byte, wr_opcode;
    logic [31:0] wr_arg;

    always #10 clk = ~clk;

    la_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .wr_stb(wr_stb), .wr_opcode(wr_opcode), .wr_arg(wr_arg),
        .reset_stb(reset_stb), .run_stb(run_stb), .meta_stb(meta_stb)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference model
    int          m_pend, m_cnt, m_idx;
    bit          m_send, m_id, m_rst, m_run, m_meta, m_wr;
    logic [7:0]  m_op, m_wop;
    logic [31:0] m_arg, m_warg;
    byte         id_str[4] = '{8'h31, 8'h53, 8'h4C, 8'h4F};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_cnt = 0; m_idx = 0; m_send = 0; m_id = 0;
            m_rst = 0; m_run = 0; m_meta = 0; m_wr = 0;
        end else begin
            if (m_send) begin
                if (tx_ready) begin
                    m_idx++;
                    if (m_idx == 4) m_send = 0;
                end
            end else if (m_id) begin
                m_send = 1; m_idx = 0;
            end
            m_id = 0; m_rst = 0; m_run = 0; m_meta = 0; m_wr = 0;
            if (rx_valid) begin
                if (m_pend == 0) begin
                    if (rx_byte[7]) begin
                        m_op = rx_byte; m_pend = 4; m_cnt = 0; m_arg = 0;
                    end else begin
                        m_rst  = (rx_byte == 8'h00);
                        m_run  = (rx_byte == 8'h01);
                        m_id   = (rx_byte == 8'h02);
                        m_meta = (rx_byte == 8'h04);
                    end
                end else begin
                    m_arg = m_arg | (32'(rx_byte) << (8 * m_cnt));
                    m_cnt++; m_pend--;
                    if (m_pend == 0) begin
                        m_wr = 1; m_wop = m_op; m_warg = m_arg;
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2", "wr_stb", wr_stb, m_wr);
            if (m_wr) begin
                chk("R2", "wr_opcode", wr_opcode, m_wop);
                chk("R2", "wr_arg", wr_arg, m_warg);
            end
            chk("R3", "reset_stb", reset_stb, m_rst);
            chk("R5", "run_stb", run_stb, m_run);
            chk("R5", "meta_stb", meta_stb, m_meta);
            chk("R6", "tx_valid", tx_valid, m_send);
            if (m_send) chk("R7", "tx_byte", tx_byte, id_str[m_idx]);
        end
    end

    int ready_mode = 0;
    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        case (ready_mode)
            0: tx_ready <= 1'b1;
            1: tx_ready <= (cyc % 3) == 0;
            default: tx_ready <= 1'b0;
        endcase
    end

    task automatic send(input logic [7:0] b, input int gap);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0; rx_byte = 8'hA5;
        repeat (gap) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9", "reset tx_valid", tx_valid, 0);
        chk("R9", "reset strobes", {wr_stb, reset_stb, run_stb, meta_stb}, 0);
        rst_n = 1'b1;
        idle(2);
        // R3 reset opcode, R4 five zeros from idle
        for (int i = 0; i < 5; i++) send(8'h00, 0);
        // R5 run and meta
        send(8'h01, 1);
        send(8'h04, 3);
        // R9 unknown short opcodes
        send(8'h03, 0); send(8'h7F, 0); send(8'h10, 2);
        // R1 R2 long command back to back bytes
        send(8'h81, 0); send(8'h11, 0); send(8'h22, 0); send(8'h33, 0); send(8'h44, 0);
        send(8'h01, 2);
        // R2 long command with gaps, arg bytes with bit 7 set
        send(8'hC0, 2); send(8'h80, 1); send(8'h02, 3); send(8'h00, 0); send(8'hFF, 1);
        // R1 zero-valued and short-looking argument bytes
        send(8'h9A, 0); send(8'h01, 0); send(8'h04, 0); send(8'h02, 0); send(8'h00, 2);
        // R4 partial long command then five zeros, then run
        send(8'h80, 0); send(8'hAA, 0);
        for (int i = 0; i < 5; i++) send(8'h00, 0);
        send(8'h01, 2);
        send(8'hF0, 0);
        for (int i = 0; i < 5; i++) send(8'h00, 1);
        send(8'h04, 2);
        // R6 identify, ready always
        ready_mode = 0;
        send(8'h02, 8);
        // R7 identify with sparse ready
        ready_mode = 1;
        send(8'h02, 1);
        // R8 identify again while reply in progress
        send(8'h02, 1);
        send(8'h01, 20);
        // R7 ready held low, then released
        ready_mode = 2;
        send(8'h02, 10);
        send(8'h02, 2);
        ready_mode = 0;
        idle(10);
        // R5 meta causes no transmit
        send(8'h04, 6);
        // R6 request right after a reply ends
        send(8'h02, 0); send(8'h82, 0); send(8'h01, 0); send(8'h02, 0); send(8'h03, 0); send(8'h04, 6);
        idle(5);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule